// File: doc/BRIEF.md
# Multi-channel down-counting PWM timer bank

The block holds a row of identical down-counting timers behind one memory-mapped register port. The port carries an address, write data, a write strobe, a read strobe and read data. Each timer runs in one of three ways: as a free-running counter that wraps on expiry, as a periodic timer that reloads a programmed count, or as a pulse-width generator. A pulse-width generator alternates a low phase and a high phase on its output pin, and each phase has its own count register.

Every expiry of a counter sets a sticky raw interrupt flag. A per-channel mask gates that flag onto the interrupt output. Software clears the flags by reading end-of-interrupt locations, either one channel at a time or all at once. Neither phase of the pulse output can be empty: a count of N always gives N+1 clock cycles. As a result, constant-high and constant-low outputs cannot be produced while a channel is enabled.

Top module: `pwt_bank`

## Requirements
- R1: Each channel c owns a register group at byte address 0x14*c. In that group, offset 0x00 is the low-phase count, 0x04 the live counter, 0x08 control, 0x0C the channel clear and 0x10 the channel masked status in bit 0. The high-phase count of channel c is at 0xB0+4*c. Read data appears on the clock after the read strobe. Count and control registers read back what was written, and unmapped addresses read zero.
- R2: The control register holds enable in bit 0 and reload mode in bit 1 (1 = reload from the low-phase count, 0 = wrap). Bit 2 is the interrupt mask (1 = masked) and bit 3 selects pulse-width mode.
- R3: When enable goes from 0 to 1, the counter takes the low-phase count and the output starts in its low phase. Rewriting control while the channel is already enabled does not reload the counter.
- R4: While a channel is enabled and its counter is not zero, the counter drops by one each clock.
- R5: In reload mode without pulse-width mode, a counter at zero takes the low-phase count on the next clock.
- R6: In wrap mode without pulse-width mode, a counter at zero becomes all ones on the next clock.
- R7: In pulse-width mode the output stays low for (low-phase count + 1) clocks and then high for (high-phase count + 1) clocks, and it repeats this forever. Outside pulse-width mode the output stays low.
- R8: While a channel is disabled, its output is low and its counter holds its value, which the live-counter register still returns.
- R9: Every expiry (counter at zero while enabled) sets the channel's raw flag. The flag stays set until it is cleared.
- R10: Masked status is the raw flag AND NOT the mask. The global status word at 0xA0 holds it per channel in bit c, and so does the irq output. The global raw word at 0xA8 holds the raw flags in bit c.
- R11: A read of a channel's clear location clears only that channel's raw flag. A read of 0xA4 clears all raw flags.
- R12: Address 0xAC returns the version parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW (8) | Byte address of the access |
| wdata | input | DW (32) | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; also triggers clear-on-read |
| rdata | output | DW (32) | Read data |
| pwm_out | output | NCH (8) | Pulse outputs, one per channel |
| irq | output | NCH (8) | Masked interrupt flags, one per channel |

## Verification
The hardest thing to reach from the ports is an exact phase length counted from the very clock that enables a channel. The first low phase must match the later ones, with no extra load cycle. The bench therefore samples the output on every falling edge, starting from the edge right after the enabling write, and counts run lengths over two full periods. Raw flags keep changing while counters run. So the interrupt scenario first disables the channels, leaving their flags frozen, and only then reads the raw, masked and per-channel status and clears them one by one.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
   // Control bits; positions are software-visible.
   typedef struct packed {
      logic pwm;    // bit 3
      logic mask;   // bit 2
      logic user;   // bit 1
      logic en;     // bit 0
   } pwt_ctl_t;

   localparam int CH_STRIDE = 20;
   localparam int OFS_LD1   = 0;
   localparam int OFS_CUR   = 4;
   localparam int OFS_CTL   = 8;
   localparam int OFS_EOI   = 12;
   localparam int OFS_STS   = 16;
   localparam int ADR_GSTS  = 'hA0;
   localparam int ADR_GEOI  = 'hA4;
   localparam int ADR_GRAW  = 'hA8;
   localparam int ADR_VER   = 'hAC;
   localparam int ADR_LD2   = 'hB0;
endpackage

// File: rtl/pwt_decode.sv
module pwt_decode
   import pwt_pkg::*;
#(
   parameter int NCH = 8,
   parameter int AW  = 8
) (
   input  logic [AW-1:0]  addr,
   output logic [NCH-1:0] hit_ld1,
   output logic [NCH-1:0] hit_ld2,
   output logic [NCH-1:0] hit_cur,
   output logic [NCH-1:0] hit_ctl,
   output logic [NCH-1:0] hit_eoi,
   output logic [NCH-1:0] hit_sts,
   output logic           hit_gsts,
   output logic           hit_geoi,
   output logic           hit_graw,
   output logic           hit_ver
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int BASE = c * CH_STRIDE;
      assign hit_ld1[c] = (addr == AW'(BASE + OFS_LD1));
      assign hit_cur[c] = (addr == AW'(BASE + OFS_CUR));
      assign hit_ctl[c] = (addr == AW'(BASE + OFS_CTL));
      assign hit_eoi[c] = (addr == AW'(BASE + OFS_EOI));
      assign hit_sts[c] = (addr == AW'(BASE + OFS_STS));
      assign hit_ld2[c] = (addr == AW'(ADR_LD2 + 4 * c));
   end

   assign hit_gsts = (addr == AW'(ADR_GSTS));
   assign hit_geoi = (addr == AW'(ADR_GEOI));
   assign hit_graw = (addr == AW'(ADR_GRAW));
   assign hit_ver  = (addr == AW'(ADR_VER));
endmodule

// File: rtl/pwt_chan.sv
module pwt_chan
   import pwt_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] wdata,
   input  logic          wr_ld1,
   input  logic          wr_ld2,
   input  logic          wr_ctl,
   input  logic          clr,
   output logic [DW-1:0] ld1_o,
   output logic [DW-1:0] ld2_o,
   output pwt_ctl_t      ctl_o,
   output logic [DW-1:0] cnt_o,
   output logic          raw_o,
   output logic          pwm_o
);
   logic [DW-1:0] ld1_q, ld2_q, cnt_q;
   pwt_ctl_t      ctl_q, ctl_new;
   logic          hi_q, raw_q;
   logic          expire, arm;

   assign ctl_new = pwt_ctl_t'(wdata[3:0]);
   assign expire  = ctl_q.en && (cnt_q == '0);
   assign arm     = wr_ctl && ctl_new.en && !ctl_q.en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld1_q <= '0;
         ld2_q <= '0;
         ctl_q <= '0;
         cnt_q <= '0;
         hi_q  <= 1'b0;
         raw_q <= 1'b0;
      end else begin
         if (wr_ld1) ld1_q <= wdata;
         if (wr_ld2) ld2_q <= wdata;
         if (wr_ctl) ctl_q <= ctl_new;

         if (arm) begin
            cnt_q <= ld1_q;
            hi_q  <= 1'b0;
         end else if (ctl_q.en) begin
            if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end else if (ctl_q.pwm) begin
               hi_q  <= !hi_q;
               cnt_q <= hi_q ? ld1_q : ld2_q;
            end else if (ctl_q.user) begin
               cnt_q <= ld1_q;
            end else begin
               cnt_q <= '1;
            end
         end

         if (expire)   raw_q <= 1'b1;
         else if (clr) raw_q <= 1'b0;
      end
   end

   assign ld1_o = ld1_q;
   assign ld2_o = ld2_q;
   assign ctl_o = ctl_q;
   assign cnt_o = cnt_q;
   assign raw_o = raw_q;
   assign pwm_o = ctl_q.en && ctl_q.pwm && hi_q;
endmodule

// File: rtl/pwt_bank.sv
module pwt_bank
   import pwt_pkg::*;
#(
   parameter int          NCH       = 8,
   parameter int          DW        = 32,
   parameter int          AW        = 8,
   parameter bit          READ_FLOP = 1'b1,
   parameter logic [31:0] VERSION   = 32'h0001_0200
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  addr,
   input  logic [DW-1:0]  wdata,
   input  logic           wr_en,
   input  logic           rd_en,
   output logic [DW-1:0]  rdata,
   output logic [NCH-1:0] pwm_out,
   output logic [NCH-1:0] irq
);
   localparam int TOP_ADR = ADR_LD2 + 4 * NCH;

   if (NCH < 1 || NCH * CH_STRIDE > ADR_GSTS) begin : g_bad_nch
      $error("pwt_bank: NCH does not fit below the global registers");
   end
   if (TOP_ADR > (1 << AW)) begin : g_bad_aw
      $error("pwt_bank: AW too narrow for the register map");
   end
   if (DW < NCH || DW < 4 || DW > 32) begin : g_bad_dw
      $error("pwt_bank: DW must cover NCH and the control bits");
   end

   logic [NCH-1:0] hit_ld1, hit_ld2, hit_cur, hit_ctl, hit_eoi, hit_sts;
   logic           hit_gsts, hit_geoi, hit_graw, hit_ver;

   pwt_decode #(.NCH(NCH), .AW(AW)) u_dec (
      .addr     (addr),
      .hit_ld1  (hit_ld1),
      .hit_ld2  (hit_ld2),
      .hit_cur  (hit_cur),
      .hit_ctl  (hit_ctl),
      .hit_eoi  (hit_eoi),
      .hit_sts  (hit_sts),
      .hit_gsts (hit_gsts),
      .hit_geoi (hit_geoi),
      .hit_graw (hit_graw),
      .hit_ver  (hit_ver)
   );

   logic [NCH-1:0][DW-1:0] ld1_v, ld2_v, cnt_v;
   pwt_ctl_t               ctl_v [NCH];
   logic [NCH-1:0]         raw_v, sts_v, clr_v, en_v, pmd_v;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign clr_v[c] = rd_en && (hit_eoi[c] || hit_geoi);
      pwt_chan #(.DW(DW)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .wdata  (wdata),
         .wr_ld1 (wr_en && hit_ld1[c]),
         .wr_ld2 (wr_en && hit_ld2[c]),
         .wr_ctl (wr_en && hit_ctl[c]),
         .clr    (clr_v[c]),
         .ld1_o  (ld1_v[c]),
         .ld2_o  (ld2_v[c]),
         .ctl_o  (ctl_v[c]),
         .cnt_o  (cnt_v[c]),
         .raw_o  (raw_v[c]),
         .pwm_o  (pwm_out[c])
      );
      assign sts_v[c] = raw_v[c] && !ctl_v[c].mask;
      assign en_v[c]  = ctl_v[c].en;
      assign pmd_v[c] = ctl_v[c].pwm;
   end

   assign irq = sts_v;

   logic [DW-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NCH; c++) begin
         if (hit_ld1[c]) rd_mux |= ld1_v[c];
         if (hit_ld2[c]) rd_mux |= ld2_v[c];
         if (hit_cur[c]) rd_mux |= cnt_v[c];
         if (hit_ctl[c]) rd_mux |= DW'(ctl_v[c]);
         if (hit_sts[c]) rd_mux |= DW'(sts_v[c]);
      end
      if (hit_gsts) rd_mux |= DW'(sts_v);
      if (hit_graw) rd_mux |= DW'(raw_v);
      if (hit_ver)  rd_mux |= DW'(VERSION);
   end

   if (READ_FLOP) begin : g_rd_flop
      logic [DW-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rdata_q <= '0;
         else if (rd_en) rdata_q <= rd_mux;
      end
      assign rdata = rdata_q;
   end else begin : g_rd_comb
      assign rdata = rd_mux;
   end
endmodule

// File: rtl/pwt_bank_chk.sv
module pwt_bank_chk #(
   parameter int NCH = 8,
   parameter int DW  = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NCH-1:0]         en,
   input logic [NCH-1:0]         pmd,
   input logic [NCH-1:0]         pwm_out,
   input logic [NCH-1:0]         raw,
   input logic [NCH-1:0]         clr,
   input logic [NCH-1:0][DW-1:0] cnt,
   input logic [NCH-1:0][DW-1:0] ld1
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      p_load_on_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(en[c]) |-> (cnt[c] == ld1[c]) && !pwm_out[c]);

      p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (en[c] && $past(en[c]) && ($past(cnt[c]) != '0)) |-> (cnt[c] == $past(cnt[c]) - 1'b1));

      p_toggle_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (en[c] && $past(en[c]) && pmd[c] && $past(pmd[c]) && ($past(cnt[c]) != '0))
         |-> $stable(pwm_out[c]));

      p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !en[c] |-> !pwm_out[c]);

      p_off_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (!en[c] && $past(!en[c])) |-> $stable(cnt[c]));

      p_raw_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $past(raw[c] && !clr[c]) |-> raw[c]);

      p_raw_from_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(raw[c]) |-> $past(en[c] && (cnt[c] == '0)));
   end
endmodule

bind pwt_bank pwt_bank_chk #(.NCH(NCH), .DW(DW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (en_v),
   .pmd     (pmd_v),
   .pwm_out (pwm_out),
   .raw     (raw_v),
   .clr     (clr_v),
   .cnt     (cnt_v),
   .ld1     (ld1_v)
);

// File: tb/sim_pwt_bank.sv
module sim_pwt_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] rdata;
   logic [7:0]  pwm_out;
   logic [7:0]  irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   pwt_bank u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wdata   (wdata),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .rdata   (rdata),
      .pwm_out (pwm_out),
      .irq     (irq)
   );

   always #2 clk = !clk;

   function automatic logic [7:0] a_ld1(int c); return 8'(c * 20);        endfunction
   function automatic logic [7:0] a_cur(int c); return 8'(c * 20 + 4);    endfunction
   function automatic logic [7:0] a_ctl(int c); return 8'(c * 20 + 8);    endfunction
   function automatic logic [7:0] a_eoi(int c); return 8'(c * 20 + 12);   endfunction
   function automatic logic [7:0] a_sts(int c); return 8'(c * 20 + 16);   endfunction
   function automatic logic [7:0] a_ld2(int c); return 8'('hB0 + 4 * c);  endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // Both tasks start and end at a falling edge.
   task automatic wr(logic [7:0] a, logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic run_len(int c, logic lvl, output int n);
      n = 0;
      while (pwm_out[c] == lvl && n < 2000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R8 reset pwm_out", 32'(pwm_out), 32'h0);
      chk("R10 reset irq", 32'(irq), 32'h0);
      rd(8'hA8, d); chk("R10 reset raw", d, 32'h0);
      rd(a_cur(0), d); chk("R8 reset counter", d, 32'h0);
      rd(a_ctl(3), d); chk("R2 reset control", d, 32'h0);
   endtask

   task automatic t_regmap();
      logic [31:0] d;
      wr(a_ld1(6), 32'hDEAD_BEEF);
      wr(a_ld2(6), 32'h1234_5678);
      wr(a_ld2(7), 32'h0000_00A5);
      wr(a_ctl(6), 32'h0000_000C);
      rd(a_ld1(6), d); chk("R1 low count readback", d, 32'hDEAD_BEEF);
      rd(a_ld2(6), d); chk("R1 high count readback", d, 32'h1234_5678);
      rd(a_ld2(7), d); chk("R1 last high count", d, 32'h0000_00A5);
      rd(a_ctl(6), d); chk("R2 control readback", d, 32'h0000_000C);
      rd(8'hF0, d);    chk("R1 unmapped zero", d, 32'h0);
      rd(8'hAC, d);    chk("R12 version", d, 32'h0001_0200);
      wr(a_ctl(6), 32'h0);
   endtask

   task automatic t_wrap();
      logic [31:0] d;
      wr(a_ld1(0), 32'd2);
      wr(a_ctl(0), 32'h1);
      rd(a_cur(0), d); chk("R3 loaded on enable", d, 32'd2);
      rd(a_cur(0), d); chk("R4 count 1", d, 32'd1);
      rd(a_cur(0), d); chk("R4 count 0", d, 32'd0);
      rd(a_cur(0), d); chk("R6 wrap all ones", d, 32'hFFFF_FFFF);
      rd(a_cur(0), d); chk("R6 after wrap", d, 32'hFFFF_FFFE);
      chk("R7 no pulse outside pwm mode", 32'(pwm_out[0]), 32'h0);
      wr(a_ctl(0), 32'h1);
      rd(a_cur(0), d); chk("R3 no reload when already on", 32'(d > 32'h1000), 32'h1);
      wr(a_ctl(0), 32'h0);
   endtask

   task automatic t_reload();
      logic [31:0] d;
      wr(a_ld1(1), 32'd2);
      wr(a_ctl(1), 32'h3);
      rd(a_cur(1), d); chk("R5 start", d, 32'd2);
      rd(a_cur(1), d); chk("R5 step 1", d, 32'd1);
      rd(a_cur(1), d); chk("R5 step 0", d, 32'd0);
      rd(a_cur(1), d); chk("R5 reloaded", d, 32'd2);
      rd(a_cur(1), d); chk("R5 after reload", d, 32'd1);
      wr(a_ctl(1), 32'h2);
      rd(a_cur(1), d);
      repeat (5) @(negedge clk);
      begin
         logic [31:0] d2;
         rd(a_cur(1), d2); chk("R8 counter frozen", d2, d);
      end
   endtask

   task automatic t_pwm(int c, int lo, int hi, bit stop_high);
      int n;
      wr(a_ld1(c), 32'(lo));
      wr(a_ld2(c), 32'(hi));
      wr(a_ctl(c), 32'h9);
      run_len(c, 1'b0, n); chk($sformatf("R7 ch%0d first low", c), 32'(n), 32'(lo + 1));
      run_len(c, 1'b1, n); chk($sformatf("R7 ch%0d first high", c), 32'(n), 32'(hi + 1));
      run_len(c, 1'b0, n); chk($sformatf("R7 ch%0d second low", c), 32'(n), 32'(lo + 1));
      if (stop_high) begin
         chk("R7 high at stop point", 32'(pwm_out[c]), 32'h1);
         wr(a_ctl(c), 32'h8);
         chk("R8 low once disabled", 32'(pwm_out[c]), 32'h0);
      end else begin
         run_len(c, 1'b1, n); chk($sformatf("R7 ch%0d second high", c), 32'(n), 32'(hi + 1));
         wr(a_ctl(c), 32'h8);
      end
   endtask

   task automatic t_irq();
      logic [31:0] d;
      rd(8'hA4, d);
      rd(8'hA8, d); chk("R11 global clear", d, 32'h0);
      wr(a_ld1(4), 32'd1);
      wr(a_ld1(5), 32'd1);
      wr(a_ctl(4), 32'h7);
      wr(a_ctl(5), 32'h3);
      repeat (6) @(negedge clk);
      wr(a_ctl(4), 32'h6);
      wr(a_ctl(5), 32'h2);
      rd(8'hA8, d);    chk("R9 raw flags", d, 32'h30);
      rd(8'hA0, d);    chk("R10 masked global", d, 32'h20);
      chk("R10 irq output", 32'(irq), 32'h20);
      rd(a_sts(4), d); chk("R10 ch4 masked", d, 32'h0);
      rd(a_sts(5), d); chk("R10 ch5 status", d, 32'h1);
      wr(a_ctl(4), 32'h2);
      rd(8'hA0, d);    chk("R10 unmask shows flag", d, 32'h30);
      rd(a_eoi(5), d);
      rd(8'hA8, d);    chk("R11 channel clear only", d, 32'h10);
      rd(8'hA4, d);
      rd(8'hA8, d);    chk("R11 global clear all", d, 32'h0);
      chk("R10 irq cleared", 32'(irq), 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_wrap();
      t_reload();
      t_pwm(2, 2, 4, 1'b1);
      t_pwm(3, 5, 1, 1'b0);
      t_pwm(7, 0, 0, 1'b0);
      t_irq();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule